// File: doc/BRIEF.md
# USB OUT Endpoint Receive Engine

This block stores the data stage of an OUT transaction for one USB function endpoint. After a decoded OUT-token strobe, it takes the byte stream of the following data packet. The first byte is the DATA0/DATA1 PID. It writes every byte into the buffers of a small ring of receive descriptors. Each descriptor owns a fixed-size buffer. A packet longer than one buffer continues into the next descriptor of the ring. A descriptor is closed when its buffer fills or when the packet ends. An interrupt pulse is raised for a closed descriptor whose interrupt enable is set.

When the packet ends, the engine picks the handshake to return to the host. The choice comes from a 2-bit per-endpoint mode and from the CRC and bit-stuff error flags that arrive with end-of-packet. Serial decoding, CRC generation, unstuffing and data-toggle checking belong to neighbouring blocks. Software arms descriptors through a one-cycle arm strobe. It reads descriptor status and buffer bytes through two combinational read ports.

Top module: `ep_out_rx`

## Requirements
- R1: After reset every descriptor reads all-zero (not empty, no interrupt enable, no wrap, no last, error 0, count 0). `hs_valid` and `irq` are low, and the ring position is entry 0.
- R2: An arm strobe on entry k sets its empty bit and loads its interrupt-enable and wrap bits from the arm inputs. It also clears that entry's last bit, error field and count.
- R3: After an OUT token, packet bytes are stored in arrival order. The PID byte is stored first, at offset 0 of the first descriptor used, and its value is never checked.
- R4: When a buffer receives its BUF_BYTES-th byte, that descriptor's empty bit clears and its count becomes BUF_BYTES. `irq` is high for exactly one cycle, in the cycle after that byte is taken, if the descriptor's interrupt enable is set.
- R5: The descriptor after entry k is entry 0 if k has its wrap bit set or k is the highest index, and entry k+1 otherwise. The engine looks at a descriptor only when a byte must be stored there.
- R6: If the descriptor needed for a byte is not empty, that byte and the rest of the packet are dropped and the busy descriptor is left unchanged. Error bit 1 (overrun) is set in the last descriptor that packet used, if the packet used one.
- R7: At end of packet an open descriptor is closed: empty cleared, count = bytes stored, last set, and `irq` one cycle later if its interrupt enable is set. If the packet ended exactly on a buffer boundary or was cut short by R6, the descriptor already used only gets its last bit, with no second interrupt.
- R8: If the CRC or bit-stuff error flag is high with end-of-packet, error bit 0 is set in the last descriptor the packet used, and no handshake is sent.
- R9: For an error-free packet, the handshake is a one-cycle `hs_valid` pulse in the cycle after end-of-packet, chosen by `hs_mode`: 00 gives code 01 (ACK), 01 gives no pulse, 10 gives code 10 (NAK), 11 gives code 11 (STALL). This also holds when no byte could be stored. `hs_code` is 00 whenever `hs_valid` is low.
- R10: The ring position carries over between packets. A packet starts at the entry after the last descriptor closed by a buffer fill or end-of-packet.
- R11: Bytes and end-of-packet strobes that arrive with no preceding OUT token change no descriptor and produce no handshake or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_out | input | 1 | Decoded OUT-token strobe |
| rx_valid | input | 1 | A packet byte is present on rx_data |
| rx_data | input | 8 | Packet byte |
| rx_eop | input | 1 | End-of-packet strobe (never with rx_valid) |
| rx_crc_err | input | 1 | CRC error flag, sampled with rx_eop |
| rx_stuff_err | input | 1 | Bit-stuff error flag, sampled with rx_eop |
| hs_mode | input | 2 | Receive handshake mode of the endpoint |
| arm_en | input | 1 | Arm strobe for one descriptor |
| arm_idx | input | IDX_W | Descriptor to arm |
| arm_ie | input | 1 | Interrupt enable loaded by arm |
| arm_wrap | input | 1 | Wrap bit loaded by arm |
| stat_idx | input | IDX_W | Descriptor selected for status read |
| stat_empty | output | 1 | Empty bit of the selected descriptor |
| stat_ie | output | 1 | Interrupt enable of the selected descriptor |
| stat_wrap | output | 1 | Wrap bit of the selected descriptor |
| stat_last | output | 1 | Last bit of the selected descriptor |
| stat_err | output | 2 | Error field: bit 0 data error, bit 1 overrun |
| stat_count | output | 8 | Byte count of the selected descriptor |
| rd_idx | input | IDX_W | Descriptor selected for buffer read |
| rd_off | input | OFF_W | Byte offset inside the buffer |
| rd_data | output | 8 | Buffer byte |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | Handshake: 01 ACK, 10 NAK, 11 STALL |
| irq | output | 1 | Descriptor-closed interrupt pulse |

## Verification
A wrong ring position or a stale open/used flag in the engine shows up as packet bytes landing at the wrong descriptor or offset. It also shows up as a count or last bit on the wrong entry, visible on the status port as soon as the packet ends. Because the ring position persists, a single off-by-one also corrupts every later packet, and the back-to-back packet phase exposes it within one or two packets. A wrong handshake or error decision is visible one cycle after end-of-packet on `hs_valid`/`hs_code`. An interrupt fired for the wrong descriptor shows as a wrong pulse count for the packet.

// File: rtl/ep_out_rx_pkg.sv
package ep_out_rx_pkg;

    localparam int unsigned EP_NUM_BD_DEF    = 4;
    localparam int unsigned EP_BUF_BYTES_DEF = 8;
    localparam int unsigned EP_CNT_W         = 8;

    // error field bit positions
    localparam int unsigned ERR_DATA_BIT = 0;
    localparam int unsigned ERR_OVR_BIT  = 1;

    typedef enum logic [1:0] {
        HSM_ACK    = 2'b00,
        HSM_SILENT = 2'b01,
        HSM_NAK    = 2'b10,
        HSM_STALL  = 2'b11
    } hs_mode_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef enum logic {
        ST_IDLE,
        ST_DATA
    } rx_state_e;

    typedef struct packed {
        logic                empty;
        logic                ie;
        logic                wrap;
        logic                last;
        logic [1:0]          err;
        logic [EP_CNT_W-1:0] count;
    } bd_t;

    function automatic hs_code_e hs_select(input logic [1:0] mode, input logic bad);
        hs_code_e code;
        if (bad) begin
            code = HS_NONE;
        end else begin
            unique case (hs_mode_e'(mode))
                HSM_ACK:    code = HS_ACK;
                HSM_SILENT: code = HS_NONE;
                HSM_NAK:    code = HS_NAK;
                default:    code = HS_STALL;
            endcase
        end
        return code;
    endfunction

endpackage

// File: rtl/ep_bd_ring.sv
module ep_bd_ring
    import ep_out_rx_pkg::*;
#(
    parameter int unsigned NUM_BD = EP_NUM_BD_DEF,
    localparam int unsigned IDX_W = $clog2(NUM_BD)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_en,
    input  logic [IDX_W-1:0]    arm_idx,
    input  logic                arm_ie,
    input  logic                arm_wrap,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic                upd_close,
    input  logic [EP_CNT_W-1:0] upd_count,
    input  logic                upd_last,
    input  logic [1:0]          upd_err,
    input  logic [IDX_W-1:0]    stat_idx,
    output bd_t                 stat_q,
    output logic [NUM_BD-1:0]   empty_v,
    output logic [NUM_BD-1:0]   ie_v,
    output logic [NUM_BD-1:0]   wrap_v
);

    bd_t ring_q [NUM_BD];

    for (genvar k = 0; k < NUM_BD; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ring_q[k] <= '0;
            end else if (upd_en && upd_idx == IDX_W'(k)) begin
                // engine update has priority over an arm of the same entry
                if (upd_close) begin
                    ring_q[k].empty <= 1'b0;
                    ring_q[k].count <= upd_count;
                end
                if (upd_last) begin
                    ring_q[k].last <= 1'b1;
                end
                ring_q[k].err <= ring_q[k].err | upd_err;
            end else if (arm_en && arm_idx == IDX_W'(k)) begin
                ring_q[k].empty <= 1'b1;
                ring_q[k].ie    <= arm_ie;
                ring_q[k].wrap  <= arm_wrap;
                ring_q[k].last  <= 1'b0;
                ring_q[k].err   <= 2'b00;
                ring_q[k].count <= '0;
            end
        end

        assign empty_v[k] = ring_q[k].empty;
        assign ie_v[k]    = ring_q[k].ie;
        assign wrap_v[k]  = ring_q[k].wrap;
    end

    assign stat_q = ring_q[stat_idx];

endmodule

// File: rtl/ep_rx_store.sv
module ep_rx_store
    import ep_out_rx_pkg::*;
#(
    parameter int unsigned NUM_BD    = EP_NUM_BD_DEF,
    parameter int unsigned BUF_BYTES = EP_BUF_BYTES_DEF,
    localparam int unsigned IDX_W    = $clog2(NUM_BD),
    localparam int unsigned OFF_W    = $clog2(BUF_BYTES),
    localparam int unsigned DEPTH    = NUM_BD * BUF_BYTES,
    localparam int unsigned AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    assign wr_addr = AW'(wr_idx) * AW'(BUF_BYTES) + AW'(wr_off);
    assign rd_addr = AW'(rd_idx) * AW'(BUF_BYTES) + AW'(rd_off);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
    import ep_out_rx_pkg::*;
#(
    parameter int unsigned NUM_BD    = EP_NUM_BD_DEF,
    parameter int unsigned BUF_BYTES = EP_BUF_BYTES_DEF,
    localparam int unsigned IDX_W    = $clog2(NUM_BD),
    localparam int unsigned OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tok_out,
    input  logic                rx_valid,
    input  logic                rx_eop,
    input  logic                rx_crc_err,
    input  logic                rx_stuff_err,
    input  logic [1:0]          hs_mode,
    input  logic [NUM_BD-1:0]   empty_v,
    input  logic [NUM_BD-1:0]   ie_v,
    input  logic [NUM_BD-1:0]   wrap_v,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [OFF_W-1:0]    wr_off,
    output logic                upd_en,
    output logic [IDX_W-1:0]    upd_idx,
    output logic                upd_close,
    output logic [EP_CNT_W-1:0] upd_count,
    output logic                upd_last,
    output logic [1:0]          upd_err,
    output logic                hs_valid,
    output logic [1:0]          hs_code,
    output logic                irq
);

    rx_state_e        state_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] last_q;
    logic [OFF_W-1:0] cnt_q;
    logic             open_q;
    logic             used_q;
    logic             drop_q;
    logic             hs_valid_q;
    hs_code_e         hs_code_q;
    logic             irq_q;

    logic             byte_go;
    logic             eop_go;
    logic             can_write;
    logic             fill;
    logic             blocked;
    logic             bad;
    logic [IDX_W-1:0] next_ptr;
    hs_code_e         hs_pick;

    always_comb begin
        byte_go   = (state_q == ST_DATA) && rx_valid && !rx_eop && !drop_q;
        eop_go    = (state_q == ST_DATA) && rx_eop;
        can_write = byte_go && (open_q || empty_v[ptr_q]);
        wr_off    = open_q ? cnt_q : '0;
        fill      = can_write && (wr_off == OFF_W'(BUF_BYTES - 1));
        blocked   = byte_go && !open_q && !empty_v[ptr_q];
        bad       = rx_crc_err | rx_stuff_err;
        hs_pick   = hs_select(hs_mode, bad);
        if (wrap_v[ptr_q] || ptr_q == IDX_W'(NUM_BD - 1)) begin
            next_ptr = '0;
        end else begin
            next_ptr = ptr_q + 1'b1;
        end
    end

    assign wr_en  = can_write;
    assign wr_idx = ptr_q;

    always_comb begin
        upd_en    = 1'b0;
        upd_idx   = last_q;
        upd_close = 1'b0;
        upd_count = '0;
        upd_last  = 1'b0;
        upd_err   = 2'b00;
        if (fill) begin
            upd_en    = 1'b1;
            upd_idx   = ptr_q;
            upd_close = 1'b1;
            upd_count = EP_CNT_W'(BUF_BYTES);
        end else if (blocked && used_q) begin
            upd_en               = 1'b1;
            upd_err[ERR_OVR_BIT] = 1'b1;
        end else if (eop_go && used_q) begin
            upd_en                = 1'b1;
            upd_close             = open_q;
            upd_count             = EP_CNT_W'(cnt_q);
            upd_last              = 1'b1;
            upd_err[ERR_DATA_BIT] = bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            last_q     <= '0;
            cnt_q      <= '0;
            open_q     <= 1'b0;
            used_q     <= 1'b0;
            drop_q     <= 1'b0;
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_NONE;
            irq_q      <= 1'b0;
        end else begin
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_NONE;
            irq_q      <= (fill || (eop_go && open_q)) && ie_v[ptr_q];
            unique case (state_q)
                ST_IDLE: begin
                    if (tok_out) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                        open_q  <= 1'b0;
                        used_q  <= 1'b0;
                        drop_q  <= 1'b0;
                    end
                end
                default: begin
                    if (eop_go) begin
                        state_q    <= ST_IDLE;
                        hs_valid_q <= (hs_pick != HS_NONE);
                        hs_code_q  <= hs_pick;
                        if (open_q) begin
                            ptr_q  <= next_ptr;
                            open_q <= 1'b0;
                        end
                    end else if (fill) begin
                        ptr_q  <= next_ptr;
                        last_q <= ptr_q;
                        open_q <= 1'b0;
                        cnt_q  <= '0;
                        used_q <= 1'b1;
                    end else if (can_write) begin
                        last_q <= ptr_q;
                        open_q <= 1'b1;
                        cnt_q  <= wr_off + 1'b1;
                        used_q <= 1'b1;
                    end else if (blocked) begin
                        drop_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign hs_valid = hs_valid_q;
    assign hs_code  = hs_code_q;
    assign irq      = irq_q;

endmodule

// File: rtl/ep_out_rx.sv
module ep_out_rx
    import ep_out_rx_pkg::*;
#(
    parameter int unsigned NUM_BD    = EP_NUM_BD_DEF,
    parameter int unsigned BUF_BYTES = EP_BUF_BYTES_DEF,
    localparam int unsigned IDX_W    = $clog2(NUM_BD),
    localparam int unsigned OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tok_out,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_eop,
    input  logic                rx_crc_err,
    input  logic                rx_stuff_err,
    input  logic [1:0]          hs_mode,
    input  logic                arm_en,
    input  logic [IDX_W-1:0]    arm_idx,
    input  logic                arm_ie,
    input  logic                arm_wrap,
    input  logic [IDX_W-1:0]    stat_idx,
    output logic                stat_empty,
    output logic                stat_ie,
    output logic                stat_wrap,
    output logic                stat_last,
    output logic [1:0]          stat_err,
    output logic [EP_CNT_W-1:0] stat_count,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [OFF_W-1:0]    rd_off,
    output logic [7:0]          rd_data,
    output logic                hs_valid,
    output logic [1:0]          hs_code,
    output logic                irq
);

    logic [NUM_BD-1:0]   empty_v;
    logic [NUM_BD-1:0]   ie_v;
    logic [NUM_BD-1:0]   wrap_v;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [OFF_W-1:0]    wr_off;
    logic                upd_en;
    logic [IDX_W-1:0]    upd_idx;
    logic                upd_close;
    logic [EP_CNT_W-1:0] upd_count;
    logic                upd_last;
    logic [1:0]          upd_err;
    bd_t                 stat_q;

    ep_rx_ctrl #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tok_out      (tok_out),
        .rx_valid     (rx_valid),
        .rx_eop       (rx_eop),
        .rx_crc_err   (rx_crc_err),
        .rx_stuff_err (rx_stuff_err),
        .hs_mode      (hs_mode),
        .empty_v      (empty_v),
        .ie_v         (ie_v),
        .wrap_v       (wrap_v),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_off       (wr_off),
        .upd_en       (upd_en),
        .upd_idx      (upd_idx),
        .upd_close    (upd_close),
        .upd_count    (upd_count),
        .upd_last     (upd_last),
        .upd_err      (upd_err),
        .hs_valid     (hs_valid),
        .hs_code      (hs_code),
        .irq          (irq)
    );

    ep_bd_ring #(.NUM_BD(NUM_BD)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .arm_en    (arm_en),
        .arm_idx   (arm_idx),
        .arm_ie    (arm_ie),
        .arm_wrap  (arm_wrap),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_close (upd_close),
        .upd_count (upd_count),
        .upd_last  (upd_last),
        .upd_err   (upd_err),
        .stat_idx  (stat_idx),
        .stat_q    (stat_q),
        .empty_v   (empty_v),
        .ie_v      (ie_v),
        .wrap_v    (wrap_v)
    );

    ep_rx_store #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_off  (wr_off),
        .wr_data (rx_data),
        .rd_idx  (rd_idx),
        .rd_off  (rd_off),
        .rd_data (rd_data)
    );

    assign stat_empty = stat_q.empty;
    assign stat_ie    = stat_q.ie;
    assign stat_wrap  = stat_q.wrap;
    assign stat_last  = stat_q.last;
    assign stat_err   = stat_q.err;
    assign stat_count = stat_q.count;

endmodule

// File: rtl/ep_out_rx_chk.sv
module ep_out_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rx_eop,
    input logic       rx_crc_err,
    input logic       rx_stuff_err,
    input logic [1:0] hs_mode,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       irq
);

    AST_HS_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(rx_eop)); // R9

    AST_ERR_NO_HS: assert property (@(posedge clk) disable iff (rst)
        $past(rx_eop && (rx_crc_err || rx_stuff_err)) |-> !hs_valid); // R8

    AST_SILENT_MODE: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_eop) && $past(hs_mode) == 2'b01) |-> !hs_valid); // R9

    AST_HS_CODE_MODE: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> (hs_code == (($past(hs_mode) == 2'b00) ? 2'b01 : $past(hs_mode)))); // R9

    AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hs_valid |-> (hs_code == 2'b00)); // R9

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(rx_valid || rx_eop)); // R4

endmodule

bind ep_out_rx ep_out_rx_chk u_chk (.*);

// File: tb/ep_out_rx_tb.sv
module ep_out_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBD  = 4;
    localparam int BUFB = 8;
    localparam int IW   = $clog2(NBD);
    localparam int OW   = $clog2(BUFB);

    logic          clk = 1'b0;
    logic          rst;
    logic          tok_out, rx_valid, rx_eop, rx_crc_err, rx_stuff_err;
    logic [7:0]    rx_data;
    logic [1:0]    hs_mode;
    logic          arm_en, arm_ie, arm_wrap;
    logic [IW-1:0] arm_idx, stat_idx, rd_idx;
    logic [OW-1:0] rd_off;
    logic          stat_empty, stat_ie, stat_wrap, stat_last;
    logic [1:0]    stat_err;
    logic [7:0]    stat_count, rd_data;
    logic          hs_valid, irq;
    logic [1:0]    hs_code;

    ep_out_rx #(.NUM_BD(NBD), .BUF_BYTES(BUFB)) u_dut (
        .clk(clk), .rst(rst), .tok_out(tok_out), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_crc_err(rx_crc_err),
        .rx_stuff_err(rx_stuff_err), .hs_mode(hs_mode), .arm_en(arm_en),
        .arm_idx(arm_idx), .arm_ie(arm_ie), .arm_wrap(arm_wrap),
        .stat_idx(stat_idx), .stat_empty(stat_empty), .stat_ie(stat_ie),
        .stat_wrap(stat_wrap), .stat_last(stat_last), .stat_err(stat_err),
        .stat_count(stat_count), .rd_idx(rd_idx), .rd_off(rd_off),
        .rd_data(rd_data), .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int hs_seen = 0;
    logic [1:0] hs_last = 2'b00;
    bit done = 0;

    always @(negedge clk) begin
        if (irq) irq_seen++;
        if (hs_valid) begin
            hs_seen++;
            hs_last = hs_code;
        end
    end

    // bench model of the descriptor ring, built from the requirements
    bit         m_e [NBD];
    bit         m_ie[NBD];
    bit         m_wr[NBD];
    bit         m_ls[NBD];
    logic [1:0] m_er[NBD];
    int         m_ct[NBD];
    logic [7:0] m_buf[NBD][BUFB];
    int         m_ptr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int adv(input int p);
        return (m_wr[p] || p == NBD - 1) ? 0 : p + 1;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        tok_out = 0; rx_valid = 0; rx_data = 0; rx_eop = 0;
        rx_crc_err = 0; rx_stuff_err = 0; hs_mode = 0;
        arm_en = 0; arm_idx = 0; arm_ie = 0; arm_wrap = 0;
        stat_idx = 0; rd_idx = 0; rd_off = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NBD; k++) begin
            m_e[k] = 0; m_ie[k] = 0; m_wr[k] = 0; m_ls[k] = 0;
            m_er[k] = 2'b00; m_ct[k] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic arm(input int k, input bit ie, input bit wr);
        @(negedge clk);
        arm_en = 1; arm_idx = IW'(k); arm_ie = ie; arm_wrap = wr;
        @(negedge clk);
        arm_en = 0;
        m_e[k] = 1; m_ie[k] = ie; m_wr[k] = wr; m_ls[k] = 0;
        m_er[k] = 2'b00; m_ct[k] = 0;
    endtask

    task automatic check_table(input string tag);
        for (int k = 0; k < NBD; k++) begin
            bit bytes_ok = 1;
            stat_idx = IW'(k);
            #1;
            chk(tag, {18'd0, stat_empty, stat_ie, stat_wrap, stat_last, stat_err, stat_count},
                {18'd0, m_e[k], m_ie[k], m_wr[k], m_ls[k], m_er[k], 8'(m_ct[k])});
            for (int j = 0; j < m_ct[k] && j < BUFB; j++) begin
                rd_idx = IW'(k); rd_off = OW'(j);
                #1;
                if (rd_data !== m_buf[k][j]) begin
                    bytes_ok = 0;
                    $display("FAIL R3 bytes: bd %0d off %0d actual=%0h expected=%0h",
                             k, j, rd_data, m_buf[k][j]);
                end
            end
            n_cmp++;
            if (!bytes_ok) n_bad++;
        end
    endtask

    task automatic send(input int len, input logic [7:0] pid, input int mode,
                        input bit crc, input bit stf, input bit with_tok, input string tag);
        bit open = 0, used = 0, drop = 0;
        int cnt = 0, lst = 0, exp_irq = 0;
        int base_irq, base_hs;
        bit exp_hs;
        logic [1:0] exp_code;
        base_irq = irq_seen;
        base_hs  = hs_seen;
        @(negedge clk);
        tok_out = with_tok; hs_mode = 2'(mode);
        @(negedge clk);
        tok_out = 0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = (i == 0) ? pid : 8'((len * 7 + i * 13 + mode) & 255);
            rx_valid = 1; rx_data = b;
            if (with_tok && !drop) begin
                if (open) begin
                    m_buf[m_ptr][cnt] = b;
                    if (cnt == BUFB - 1) begin
                        m_e[m_ptr] = 0; m_ct[m_ptr] = BUFB;
                        if (m_ie[m_ptr]) exp_irq++;
                        lst = m_ptr; m_ptr = adv(m_ptr); open = 0; cnt = 0;
                    end else begin
                        cnt++;
                    end
                end else if (m_e[m_ptr]) begin
                    m_buf[m_ptr][0] = b;
                    used = 1; lst = m_ptr; open = 1; cnt = 1;
                end else begin
                    drop = 1;
                    if (used) m_er[lst][1] = 1'b1;
                end
            end
            @(negedge clk);
        end
        rx_valid = 0;
        rx_eop = 1; rx_crc_err = crc; rx_stuff_err = stf;
        @(negedge clk);
        rx_eop = 0; rx_crc_err = 0; rx_stuff_err = 0;
        if (with_tok && used) begin
            m_ls[lst] = 1;
            if (crc || stf) m_er[lst][0] = 1'b1;
            if (open) begin
                m_e[lst] = 0; m_ct[lst] = cnt;
                if (m_ie[lst]) exp_irq++;
                m_ptr = adv(m_ptr);
            end
        end
        repeat (2) @(negedge clk);
        exp_hs   = with_tok && !(crc || stf) && mode != 1;
        exp_code = (mode == 0) ? 2'b01 : 2'(mode);
        chk({tag, " R9/R8 hs count"}, hs_seen - base_hs, exp_hs ? 1 : 0);
        if (exp_hs) chk({tag, " R9 hs code"}, hs_last, exp_code);
        chk({tag, " R4/R7 irq count"}, irq_seen - base_irq, exp_irq);
        check_table({tag, " R5/R6/R7/R8 table"});
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 hs_valid", hs_valid, 0);
        chk("R1 irq", irq, 0);
        check_table("R1 reset table");

        // near-exhaustive sweep from a fresh ring
        for (int sc = 0; sc < 4; sc++) begin
            for (int len = 1; len <= NBD * BUFB + 3; len++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    for (int e = 0; e < 3; e++) begin
                        do_reset();
                        case (sc)
                            0: for (int k = 0; k < NBD; k++) arm(k, k != 1, k == NBD - 1);
                            1: for (int k = 0; k < NBD - 1; k++) arm(k, 1, 0);
                            2: begin arm(0, 1, 0); arm(1, 1, 1); end
                            default: ;
                        endcase
                        if (sc == 0 && len == 1 && mode == 0 && e == 0)
                            check_table("R2 armed");
                        send(len, (e == 2) ? 8'h00 : ((len % 2) ? 8'hC3 : 8'h4B),
                             mode, e == 1, e == 2, 1, "sweep");
                    end
                end
            end
        end

        // ring position persists across packets
        do_reset();
        for (int p = 0; p < 12; p++) begin
            for (int k = 0; k < NBD; k++) arm(k, 1, k == NBD - 1);
            send(1 + (p * 5) % 13, 8'hD2, p % 4, 0, 0, 1, "R10 seq");
        end

        // stray bytes with no token
        for (int k = 0; k < NBD; k++) arm(k, 1, 0);
        send(6, 8'h69, 0, 0, 0, 0, "R11 no token");
        send(3, 8'hE1, 2, 0, 0, 1, "R11 after stray");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule